// File: doc/BRIEF.md
# Task-Driven Two-Wire Bus Master

This block drives a two-wire (I2C-compatible) bus as master. A host starts it with single-cycle task pulses, feeds transmit bytes through a one-byte holding register, and takes received bytes from a read register. The block reports progress through single-cycle event pulses. A transfer begins with a start condition, a 7-bit slave address and a direction bit. The master then samples the slave's acknowledge and either shifts bytes out (write) or shifts them in (read). A stop task ends the transfer with a stop condition.

Whenever the host has not yet serviced a data register, the master holds SCL low. On a write it waits for a fresh transmit byte. On a read it waits for the received byte to be taken. On a read, the acknowledge bit that follows each byte is decided at the moment the host takes the byte. If a stop task is already pending at that point, the master answers NACK and stops. Otherwise it answers ACK and fetches the next byte.

The bus lines are open-drain. The block outputs drive-low enables and samples the resolved SDA level. One SCL period is four quarters of `QDIV` system clocks each.

Top module: `twi_task_master`

## Requirements
- R1: After reset both drive-low enables are 0 and no event is raised. Every event is a single-cycle pulse, and at most one event is raised per cycle.
- R2: A transfer opens with SDA falling while SCL is high (start) and closes with SDA rising while SCL is high (stop). SDA and SCL never change in the same clock cycle, and each transfer produces exactly one start and one stop.
- R3: Byte 0 on the bus is the 7-bit address, most significant bit first, followed by the direction bit. The direction bit is 0 for a write started by `task_starttx` and 1 for a read started by `task_startrx`.
- R4: The master releases SDA for the ninth clock of every address or written byte. It reads a low level as ACK.
- R5: On a write, each byte taken from the transmit register goes out most significant bit first. Each byte that is acknowledged raises `ev_txdsent` for one cycle.
- R6: After `ev_txdsent`, if no new transmit byte has been written, SCL stays low until `txd_wr` or a stop task arrives.
- R7: After a stop task, the master drives SDA low with SCL low, releases SCL, and then releases SDA. It then raises `ev_stopped`, with both lines released in that cycle.
- R8: On a read, each byte is shifted in most significant bit first. The byte appears on `rxd` in the same cycle as a one-cycle `ev_rxdrdy` pulse.
- R9: After `ev_rxdrdy`, SCL stays low and no acknowledge bit is driven until `rxd_rd` is pulsed.
- R10: When `rxd_rd` arrives, the master sends NACK (SDA released) and then a stop condition if a stop task is pending or is pulsed in that same cycle. Otherwise it sends ACK (SDA low) and receives another byte.
- R11: A NACK on the address or on a written byte raises `ev_error` and holds SCL low until a stop task arrives.
- R12: Every SCL high phase inside a transfer lasts exactly 2*`QDIV` system clock cycles.
- R13: Start tasks are ignored while a transfer is active, and `rxd_rd` is ignored unless a received byte is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| task_starttx | input | 1 | Pulse: begin a write transfer |
| task_startrx | input | 1 | Pulse: begin a read transfer |
| task_stop | input | 1 | Pulse: request a stop condition |
| slave_addr | input | 7 | Target slave address |
| txd_wr | input | 1 | Strobe: load `txd_data` into the transmit register |
| txd_data | input | 8 | Next byte to transmit |
| rxd_rd | input | 1 | Strobe: host has taken `rxd` |
| rxd | output | 8 | Last received byte |
| ev_txdsent | output | 1 | Pulse: written byte acknowledged |
| ev_rxdrdy | output | 1 | Pulse: new byte on `rxd` |
| ev_stopped | output | 1 | Pulse: stop condition finished |
| ev_error | output | 1 | Pulse: NACK on address or written byte |
| scl_oe | output | 1 | Drive SCL low when 1 |
| sda_oe | output | 1 | Drive SDA low when 1 |
| sda_in | input | 1 | Resolved SDA level |

## Verification
The bench builds the block with `QDIV` = 3, so one bit lasts 12 system clocks and a full byte with its acknowledge stays near 110 cycles. This leaves room for many random write and read transfers, each of one to four bytes, plus long host stalls of 40 cycles in both directions. A behavioural slave answers on the resolved bus. It can be set to NACK the address or any chosen data byte, which exercises the error hold. It also records the master's acknowledge bits, so the NACK-on-last-byte rule is checked, including a stop task that arrives in the very cycle the byte is read.

// File: rtl/twi_task_master.sv
module twi_task_master #(
  parameter int QDIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       task_starttx,
  input  logic       task_startrx,
  input  logic       task_stop,
  input  logic [6:0] slave_addr,
  input  logic       txd_wr,
  input  logic [7:0] txd_data,
  input  logic       rxd_rd,
  output logic [7:0] rxd,
  output logic       ev_txdsent,
  output logic       ev_rxdrdy,
  output logic       ev_stopped,
  output logic       ev_error,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_BITS, S_ACKIN, S_ACKOUT, S_WAITTX, S_WAITRX, S_STOP, S_HOLD
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [1:0]    ph;
  logic [2:0]    nb;
  logic [7:0]    sh, txq;
  logic          txf, rd, adr, stp, nak;

  wire tick    = (cnt == CW'(QDIV - 1));
  wire bit_end = tick && (ph == 2'd3);
  wire timed   = (st == S_START) || (st == S_BITS) || (st == S_ACKIN) ||
                 (st == S_ACKOUT) || (st == S_STOP);
  wire clocked = (st == S_BITS) || (st == S_ACKIN) || (st == S_ACKOUT) || (st == S_STOP);
  wire parked  = (st == S_WAITTX) || (st == S_WAITRX) || (st == S_HOLD);
  wire rx_data = rd && !adr;

  assign scl_oe = clocked ? (ph < 2'd2) : parked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      ph <= '0;
      nb <= '0;
      sh <= '0;
      txq <= '0;
      txf <= 1'b0;
      rd <= 1'b0;
      adr <= 1'b0;
      stp <= 1'b0;
      nak <= 1'b0;
      rxd <= '0;
      sda_oe <= 1'b0;
      ev_txdsent <= 1'b0;
      ev_rxdrdy <= 1'b0;
      ev_stopped <= 1'b0;
      ev_error <= 1'b0;
    end else begin
      ev_txdsent <= 1'b0;
      ev_rxdrdy <= 1'b0;
      ev_stopped <= 1'b0;
      ev_error <= 1'b0;
      if (task_stop && st != S_IDLE) stp <= 1'b1;
      if (timed) begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) ph <= ph + 2'd1;
      end else begin
        cnt <= '0;
        ph <= '0;
      end
      case (st)
        S_IDLE: begin
          sda_oe <= 1'b0;
          stp <= 1'b0;
          if (task_starttx || task_startrx) begin
            rd <= !task_starttx;
            sh <= {slave_addr, !task_starttx};
            adr <= 1'b1;
            nb <= '0;
            st <= S_START;
          end
        end
        S_START: begin
          if (tick && ph == 2'd1) sda_oe <= 1'b1;
          if (bit_end) st <= S_BITS;
        end
        S_BITS: begin
          if (tick && ph == 2'd0) sda_oe <= rx_data ? 1'b0 : !sh[7];
          if (bit_end) begin
            sh <= {sh[6:0], sda_in};
            nb <= nb + 3'd1;
            if (nb == 3'd7) begin
              if (rx_data) begin
                rxd <= {sh[6:0], sda_in};
                ev_rxdrdy <= 1'b1;
                st <= S_WAITRX;
              end else begin
                st <= S_ACKIN;
              end
            end
          end
        end
        S_ACKIN: begin
          if (tick && ph == 2'd0) sda_oe <= 1'b0;
          if (bit_end) begin
            if (sda_in) begin
              ev_error <= 1'b1;
              st <= S_HOLD;
            end else begin
              if (!adr) ev_txdsent <= 1'b1;
              adr <= 1'b0;
              st <= rd ? S_BITS : S_WAITTX;
            end
          end
        end
        S_WAITTX: begin
          if (stp) begin
            stp <= 1'b0;
            st <= S_STOP;
          end else if (txf) begin
            sh <= txq;
            txf <= 1'b0;
            st <= S_BITS;
          end
        end
        S_WAITRX: begin
          if (rxd_rd) begin
            nak <= stp || task_stop;
            st <= S_ACKOUT;
          end
        end
        S_ACKOUT: begin
          if (tick && ph == 2'd0) sda_oe <= !nak;
          if (bit_end) begin
            if (nak) begin
              stp <= 1'b0;
              st <= S_STOP;
            end else begin
              st <= S_BITS;
            end
          end
        end
        S_HOLD: begin
          if (stp) begin
            stp <= 1'b0;
            st <= S_STOP;
          end
        end
        S_STOP: begin
          if (tick && ph == 2'd0) sda_oe <= 1'b1;
          if (tick && ph == 2'd2) sda_oe <= 1'b0;
          if (bit_end) begin
            ev_stopped <= 1'b1;
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (txd_wr) begin
        txq <= txd_data;
        txf <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/twi_task_master_chk.sv
module twi_task_master_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic sda_in,
  input logic ev_txdsent,
  input logic ev_rxdrdy,
  input logic ev_stopped,
  input logic ev_error
);
  assert_one_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_txdsent, ev_rxdrdy, ev_stopped, ev_error}));

  assert_sda_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_oe) |-> $stable(sda_oe));

  assert_ack_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_txdsent |-> !$past(sda_in));

  assert_single_sent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_txdsent |=> !ev_txdsent);

  assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_txdsent |-> scl_oe);

  assert_stop_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stopped |-> (!scl_oe && !sda_oe));

  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rxdrdy |=> scl_oe);

  assert_nack_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_error |-> ($past(sda_in) && scl_oe));
endmodule

bind twi_task_master twi_task_master_chk i_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in),
  .ev_txdsent(ev_txdsent), .ev_rxdrdy(ev_rxdrdy), .ev_stopped(ev_stopped),
  .ev_error(ev_error)
);

// File: tb/test_twi_task_master.sv
`timescale 1ns/100ps
module test_twi_task_master;
  localparam int QD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic task_starttx = 0, task_startrx = 0, task_stop = 0, txd_wr = 0, rxd_rd = 0;
  logic [6:0] slave_addr = '0;
  logic [7:0] txd_data = '0;
  logic [7:0] rxd;
  logic ev_txdsent, ev_rxdrdy, ev_stopped, ev_error, scl_oe, sda_oe;
  logic s_oe;
  wire scl = !scl_oe;
  wire sda = !(sda_oe || s_oe);

  always #2.5 clk = ~clk;

  twi_task_master #(.QDIV(QD)) i_twi_task_master (
    .clk(clk), .rst_n(rst_n), .task_starttx(task_starttx), .task_startrx(task_startrx),
    .task_stop(task_stop), .slave_addr(slave_addr), .txd_wr(txd_wr), .txd_data(txd_data),
    .rxd_rd(rxd_rd), .rxd(rxd), .ev_txdsent(ev_txdsent), .ev_rxdrdy(ev_rxdrdy),
    .ev_stopped(ev_stopped), .ev_error(ev_error), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .sda_in(sda));

  int checks = 0, fails = 0;
  int nack_addr = 0, nack_at = -1;
  logic [7:0] rdata [0:255];

  // behavioural slave and bus monitor
  logic p_scl, p_sda, s_nk, s_isaddr, s_rdaddr, s_mack;
  logic [7:0] s_sh, s_cur;
  int s_mode, s_cnt, dbyte, wn, mn, rn, starts, stops, bad_edges, bad_high, hi;
  logic hv;
  logic [7:0] wlog [0:255];
  logic mack_log [0:255];

  always @(posedge clk) begin
    if (!rst_n) begin
      p_scl <= 1; p_sda <= 1; s_oe <= 0; s_mode <= 0; s_cnt <= 0; dbyte <= 0;
      wn <= 0; mn <= 0; rn <= 0; starts <= 0; stops <= 0; bad_edges <= 0; bad_high <= 0;
      hi <= 0; hv <= 0; s_nk <= 0; s_isaddr <= 0; s_rdaddr <= 0; s_mack <= 0;
      s_sh <= 0; s_cur <= 0;
    end else begin
      p_scl <= scl;
      p_sda <= sda;
      if (scl != p_scl && sda != p_sda) bad_edges <= bad_edges + 1;
      if (!p_scl && scl) begin hi <= 1; hv <= 1; end
      else if (scl) hi <= hi + 1;
      if (p_scl && !scl) begin
        if (hv && hi != 2 * QD) bad_high <= bad_high + 1;
        hv <= 0;
      end
      if (p_scl && scl && p_sda && !sda) begin
        starts <= starts + 1; s_mode <= 1; s_cnt <= 0; s_oe <= 0; dbyte <= 0; hv <= 0;
      end else if (p_scl && scl && !p_sda && sda) begin
        stops <= stops + 1; s_mode <= 0; s_oe <= 0; hv <= 0;
      end else if (!p_scl && scl) begin
        if (s_mode == 1 || s_mode == 2) begin
          s_sh <= {s_sh[6:0], sda}; s_cnt <= s_cnt + 1;
        end else if (s_mode == 5) begin
          mack_log[mn[7:0]] <= sda; mn <= mn + 1; s_mack <= sda;
        end
      end else if (p_scl && !scl) begin
        case (s_mode)
          1, 2: if (s_cnt == 8) begin
            wlog[wn[7:0]] <= s_sh; wn <= wn + 1;
            s_nk <= (s_mode == 1) ? (nack_addr != 0) : (dbyte == nack_at);
            s_oe <= (s_mode == 1) ? (nack_addr == 0) : (dbyte != nack_at);
            s_isaddr <= (s_mode == 1);
            s_rdaddr <= s_sh[0];
            if (s_mode == 2) dbyte <= dbyte + 1;
            s_mode <= 3;
          end
          3: begin
            if (s_nk) begin s_oe <= 0; s_mode <= 0; end
            else if (s_isaddr && s_rdaddr) begin
              s_mode <= 4; s_cnt <= 1; s_oe <= !rdata[rn[7:0]][7]; s_cur <= rdata[rn[7:0]];
            end else begin s_oe <= 0; s_mode <= 2; s_cnt <= 0; end
          end
          4: if (s_cnt == 8) begin s_oe <= 0; s_mode <= 5; rn <= rn + 1; end
             else begin s_oe <= !s_cur[3'(7 - s_cnt)]; s_cnt <= s_cnt + 1; end
          5: if (!s_mack) begin
               s_mode <= 4; s_cnt <= 1; s_oe <= !rdata[rn[7:0]][7]; s_cur <= rdata[rn[7:0]];
             end else begin s_oe <= 0; s_mode <= 0; end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] frame(input logic [6:0] a, input logic r);
    return {a, r};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ev(input int sel, input string req);
    bit got = 0;
    for (int n = 0; n < 4000 && !got; n++) begin
      @(negedge clk);
      case (sel)
        0: got = ev_txdsent;
        1: got = ev_rxdrdy;
        2: got = ev_stopped;
        default: got = ev_error;
      endcase
    end
    check(req, got, 1);
  endtask

  task automatic hold_low(input int cyc, input string req);
    int highs = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (scl) highs++;
    end
    check(req, highs, 0);
  endtask

  task automatic pulse_tx;    @(negedge clk); task_starttx = 1; @(negedge clk); task_starttx = 0; endtask
  task automatic pulse_rx;    @(negedge clk); task_startrx = 1; @(negedge clk); task_startrx = 0; endtask
  task automatic pulse_stop;  @(negedge clk); task_stop = 1;    @(negedge clk); task_stop = 0;    endtask
  task automatic pulse_rd;    @(negedge clk); rxd_rd = 1;       @(negedge clk); rxd_rd = 0;       endtask
  task automatic put_txd(input logic [7:0] d);
    @(negedge clk); txd_data = d; txd_wr = 1; @(negedge clk); txd_wr = 0;
  endtask

  task automatic do_write(input logic [6:0] a, input int n, input bit stall, input bit poke);
    logic [7:0] d [0:7];
    int bw = wn, st0 = starts, sp0 = stops;
    for (int i = 0; i < n; i++) d[i] = 8'($urandom);
    slave_addr = a;
    put_txd(d[0]);
    pulse_tx();
    if (poke) pulse_rx(); // R13: start task while busy
    for (int i = 0; i < n; i++) begin
      wait_ev(0, "R5 txdsent");
      @(negedge clk);
      check("R1 txdsent single cycle", ev_txdsent, 0);
      if (i < n - 1) begin
        if (stall) hold_low(40, "R6 write stall");
        put_txd(d[i + 1]);
      end
    end
    if (stall) hold_low(20, "R6 stall before stop");
    pulse_stop();
    wait_ev(2, "R7 stopped");
    @(negedge clk);
    check("R7 lines released", {scl_oe, sda_oe}, 0);
    check("R3 write address frame", wlog[bw[7:0]], frame(a, 1'b0));
    for (int i = 0; i < n; i++) check("R5 written byte", wlog[8'(bw + 1 + i)], d[i]);
    check("R13 one start per write", starts - st0, 1);
    check("R2 one stop per write", stops - sp0, 1);
  endtask

  task automatic do_read(input logic [6:0] a, input int n, input bit stall, input bit same, input bit poke);
    int bw = wn, bm = mn, br = rn, sp0 = stops;
    for (int i = 0; i < n; i++) rdata[8'(br + i)] = 8'($urandom);
    slave_addr = a;
    pulse_rx();
    if (poke) begin pulse_rd(); pulse_tx(); end // R13: both ignored
    for (int i = 0; i < n; i++) begin
      wait_ev(1, "R8 rxdrdy");
      check("R8 received byte", rxd, rdata[8'(br + i)]);
      if (stall) hold_low(40, "R9 read stall");
      if (i == n - 1) begin
        if (same) begin
          @(negedge clk); task_stop = 1; rxd_rd = 1;
          @(negedge clk); task_stop = 0; rxd_rd = 0;
        end else begin
          pulse_stop();
          hold_low(5, "R9 stop alone keeps stall");
          pulse_rd();
        end
      end else pulse_rd();
    end
    wait_ev(2, "R7 stopped after read");
    check("R3 read address frame", wlog[bw[7:0]], frame(a, 1'b1));
    check("R10 ack count", mn - bm, n);
    for (int i = 0; i < n; i++)
      check("R10 master ack bit", mack_log[8'(bm + i)], (i == n - 1) ? 1 : 0);
    check("R2 one stop per read", stops - sp0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset lines", {scl_oe, sda_oe}, 0);
    check("R1 reset events", {ev_txdsent, ev_rxdrdy, ev_stopped, ev_error}, 0);

    // directed corners
    do_write(7'h55, 2, 1, 1);
    do_read(7'h2A, 3, 1, 0, 1);
    do_read(7'h7F, 1, 0, 1, 0);   // R10 stop pulsed with the read
    do_read(7'h00, 2, 0, 1, 0);

    // R11: address NACK on a write
    nack_addr = 1;
    slave_addr = 7'h31;
    put_txd(8'hA5);
    pulse_tx();
    wait_ev(3, "R11 address nack error");
    hold_low(40, "R11 hold after nack");
    pulse_stop();
    wait_ev(2, "R11 stop after error");

    // R11: address NACK on a read
    slave_addr = 7'h12;
    pulse_rx();
    wait_ev(3, "R11 read address nack");
    pulse_stop();
    wait_ev(2, "R11 stop after read error");
    nack_addr = 0;

    // R11: NACK on second written byte
    nack_at = 1;
    slave_addr = 7'h44;
    put_txd(8'h3C);
    pulse_tx();
    wait_ev(0, "R11 first byte acked");
    put_txd(8'hC3);
    wait_ev(3, "R11 data nack error");
    hold_low(30, "R11 hold after data nack");
    pulse_stop();
    wait_ev(2, "R11 stop after data error");
    nack_at = -1;

    // random transfers
    for (int k = 0; k < 10; k++) begin
      if ($urandom % 2)
        do_write(7'($urandom), 1 + int'($urandom % 4), bit'($urandom % 2), 0);
      else
        do_read(7'($urandom), 1 + int'($urandom % 4), bit'($urandom % 2), bit'($urandom % 2), 0);
    end

    check("R2 no simultaneous line changes", bad_edges, 0);
    check("R12 scl high width", bad_high, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule